// File: doc/BRIEF.md
# Nested priority interrupt controller

This block takes a set of level-sensitive interrupt request lines. Each line has a programmable priority and an enable bit. The block turns each rising edge on a line into a pending flag. Among the pending, enabled sources it picks the most urgent one and offers its vector number to the processor side.

Once the processor accepts a vector, that vector's priority becomes the running level. Only a strictly more urgent request can then interrupt it. When a handler reports completion, the level it interrupted becomes the running level again.

A mode bit turns preemption off entirely. In that mode nothing new is offered while any handler is still active. All configuration goes through a small write-only register port.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no request is offered (`irq_req` low), no level is running (`run_valid` low), every source is disabled, every priority is 0 and preemption is allowed.
- R2: A rising edge on `irq_in[k]` sets the pending flag of source k even while k is disabled. A disabled source is never offered. Enabling it later offers the request it already latched.
- R3: Among pending, enabled sources the one with the numerically smallest priority wins. Priority 0 is the most urgent. `vector_num` carries its index and `req_prio` its priority.
- R4: When several winning sources share the same priority, the lowest source index is offered.
- R5: `irq_ack` high while `irq_req` is high clears the pending flag of the offered vector and makes its priority the running level.
- R6: With preemption allowed, a pending request whose priority is numerically smaller than the running level is offered.
- R7: A request whose priority is equal to or larger than the running level is not offered. It stays pending until the running level changes.
- R8: `irq_done` removes the running level. The previously interrupted level, if any, becomes the running level again. With no handler left, `run_valid` drops.
- R9: In non-preemptive mode, no request is offered while any level is running.
- R10: The write port uses these addresses:
  - address 0, bit 0: mode (1 = non-preemptive);
  - address 1, bit k: enable for source k;
  - address 2+g: priorities of sources 8g..8g+7. Source 8g+i takes bits [4i+2:4i].
- R11: A line held high after its request was acknowledged does not become pending again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| irq_ack | input | 1 | Processor accepts the offered vector |
| irq_done | input | 1 | Running handler has finished |
| irq_req | output | 1 | An eligible request is offered |
| vector_num | output | VEC_W | Index of the offered source |
| req_prio | output | PRIO_W | Priority of the offered source |
| run_valid | output | 1 | At least one handler is active |
| run_prio | output | PRIO_W | Running (most urgent active) level |

## Verification
The bench runs two sources through every pair of priorities in both modes.

- The second source arrives while the first is running. A design with a non-strict comparison would preempt on equal priority. One that broke the tie toward the higher index would offer the wrong vector when the priorities match.
- After each nested completion the bench checks the restored level. A stack that dropped the interrupted entry would report idle too early.
- Request lines stay high through acknowledge. A level-triggered pending flag would then re-offer the same vector.
- A directed pass writes one priority word with a distinct value in every slot. A slot-position error would serve the sources in the wrong order.
- A pseudo-random phase mixes writes, acknowledges and completions, including both in the same cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // register addresses of the write port
   localparam int REG_MODE      = 0;
   localparam int REG_ENABLE    = 1;
   localparam int REG_PRIO_BASE = 2;
   // priority packing inside one data word
   localparam int SLOTS_PER_WORD = 8;
   localparam int SLOT_W         = 4;
   localparam int DATA_W         = 32;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
   import nic_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int PRIO_W     = 3,
   parameter int ADDR_W     = 4,
   parameter bit PREEMPT_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [NUM_SRC-1:0]        src_en,
   output logic [NUM_SRC*PRIO_W-1:0] src_prio,
   output logic                      mode_nopre
);
   logic hit_en;
   assign hit_en = wr_en && (wr_addr == ADDR_W'(REG_ENABLE));

   always_ff @(posedge clk) begin
      if (!rst_n)      src_en <= '0;
      else if (hit_en) src_en <= wr_data[NUM_SRC-1:0];
   end

   generate
      if (PREEMPT_EN) begin : g_mode_reg
         logic nopre_q;
         always_ff @(posedge clk) begin
            if (!rst_n) nopre_q <= 1'b0;
            else if (wr_en && (wr_addr == ADDR_W'(REG_MODE))) nopre_q <= wr_data[0];
         end
         assign mode_nopre = nopre_q;
      end else begin : g_mode_fixed
         assign mode_nopre = 1'b1;
      end

      for (genvar k = 0; k < NUM_SRC; k++) begin : g_prio
         localparam int GRP  = k / SLOTS_PER_WORD;
         localparam int SLOT = k % SLOTS_PER_WORD;
         logic [PRIO_W-1:0] p_q;
         always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(REG_PRIO_BASE + GRP)))
               p_q <= wr_data[SLOT*SLOT_W +: PRIO_W];
         end
         assign src_prio[k*PRIO_W +: PRIO_W] = p_q;
      end
   endgenerate
endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               clr_en,
   input  logic [VEC_W-1:0]   clr_idx,
   output logic [NUM_SRC-1:0] pend
);
   logic [NUM_SRC-1:0] irq_q, rise, clr_mask;

   assign rise     = irq_in & ~irq_q;
   assign clr_mask = clr_en ? (NUM_SRC'(1) << clr_idx) : '0;

   // a fresh edge wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= '0;
         pend  <= '0;
      end else begin
         irq_q <= irq_in;
         pend  <= (pend & ~clr_mask) | rise;
      end
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 5
) (
   input  logic [NUM_SRC-1:0]        cand,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   output logic                      found,
   output logic [VEC_W-1:0]          best_idx,
   output logic [PRIO_W-1:0]         best_prio
);
   always_comb begin
      found     = 1'b0;
      best_idx  = '0;
      best_prio = '1;
      for (int k = 0; k < NUM_SRC; k++) begin
         // strict compare keeps the lower index on a tie
         if (cand[k] && (!found || (src_prio[k*PRIO_W +: PRIO_W] < best_prio))) begin
            found     = 1'b1;
            best_idx  = VEC_W'(k);
            best_prio = src_prio[k*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/nic_nest.sv
module nic_nest #(
   parameter int PRIO_W = 3,
   localparam int LEVELS = 1 << PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_lvl,
   input  logic              pop,
   output logic              run_valid,
   output logic [PRIO_W-1:0] run_prio
);
   // one bit per level; nesting is strictly increasing in urgency,
   // so the lowest set bit is the top of the stack
   logic [LEVELS-1:0] act_q, low_bit, push_bit;

   assign low_bit   = act_q & (~act_q + LEVELS'(1));
   assign push_bit  = push ? (LEVELS'(1) << push_lvl) : '0;
   assign run_valid = |act_q;

   always_comb begin
      run_prio = '0;
      for (int l = LEVELS - 1; l >= 0; l--)
         if (act_q[l]) run_prio = PRIO_W'(l);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= (act_q & ~(pop ? low_bit : '0)) | push_bit;
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int PRIO_W     = 3,
   parameter int ADDR_W     = 4,
   parameter bit PREEMPT_EN = 1'b1,
   localparam int VEC_W     = $clog2(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic                irq_ack,
   input  logic                irq_done,
   output logic                irq_req,
   output logic [VEC_W-1:0]    vector_num,
   output logic [PRIO_W-1:0]   req_prio,
   output logic                run_valid,
   output logic [PRIO_W-1:0]   run_prio
);
   localparam int GROUPS = (NUM_SRC + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;

   generate
      if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie in 2..32");
      end
      if (PRIO_W < 1 || PRIO_W > SLOT_W) begin : g_bad_prio
         $error("PRIO_W must lie in 1..4");
      end
      if (REG_PRIO_BASE + GROUPS > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the priority words");
      end
   endgenerate

   logic [NUM_SRC-1:0]        src_en, pend;
   logic [NUM_SRC*PRIO_W-1:0] src_prio;
   logic                      mode_nopre, found, take;
   logic [VEC_W-1:0]          best_idx;
   logic [PRIO_W-1:0]         best_prio;

   nic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
              .PREEMPT_EN(PREEMPT_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .src_en(src_en), .src_prio(src_prio),
      .mode_nopre(mode_nopre));

   nic_pending #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_en(take),
      .clr_idx(best_idx), .pend(pend));

   nic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
      .cand(pend & src_en), .src_prio(src_prio), .found(found),
      .best_idx(best_idx), .best_prio(best_prio));

   nic_nest #(.PRIO_W(PRIO_W)) u_nest (
      .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(best_prio),
      .pop(irq_done), .run_valid(run_valid), .run_prio(run_prio));

   assign irq_req    = found && (!run_valid || (!mode_nopre && (best_prio < run_prio)));
   assign take       = irq_req && irq_ack;
   assign vector_num = best_idx;
   assign req_prio   = best_prio;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_req,
   input logic               irq_ack,
   input logic               irq_done,
   input logic [VEC_W-1:0]   vector_num,
   input logic [PRIO_W-1:0]  req_prio,
   input logic               run_valid,
   input logic [PRIO_W-1:0]  run_prio,
   input logic               mode_nopre,
   input logic [NUM_SRC-1:0] src_en
);
   // R2
   en_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> src_en[vector_num]);
   // R6
   strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && run_valid) |-> (req_prio < run_prio));
   // R9
   no_preempt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_nopre && run_valid) |-> !irq_req);
   // R5
   push_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (run_valid && run_prio == $past(req_prio)));
   // R8
   pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && !(irq_req && irq_ack) && run_valid) |=>
         (!run_valid || (run_prio > $past(run_prio))));
endmodule

bind nest_irq_ctrl nic_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
   .irq_done(irq_done), .vector_num(vector_num), .req_prio(req_prio),
   .run_valid(run_valid), .run_prio(run_prio), .mode_nopre(mode_nopre),
   .src_en(src_en));

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 32;
   localparam int PW = 3;
   localparam int VW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          irq_ack = 1'b0, irq_done = 1'b0;
   logic          irq_req, run_valid;
   logic [VW-1:0] vector_num;
   logic [PW-1:0] req_prio, run_prio;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // reference state
   logic [N-1:0]  m_pend = '0, m_en = '0, m_prev = '0;
   logic [PW-1:0] m_prio [N];
   logic [7:0]    m_act = '0;
   logic          m_nop = 1'b0;
   logic          e_req, e_rv;
   logic [VW-1:0] e_vec;
   logic [PW-1:0] e_bp, e_rp;

   always #(CLK_PERIOD/2) clk = ~clk;

   nest_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
      .irq_done(irq_done), .irq_req(irq_req), .vector_num(vector_num),
      .req_prio(req_prio), .run_valid(run_valid), .run_prio(run_prio));

   task automatic meval();
      logic f;
      f = 1'b0; e_vec = '0; e_bp = '0;
      for (int k = 0; k < N; k++)
         if (m_pend[k] && m_en[k] && (!f || m_prio[k] < e_bp)) begin
            f = 1'b1; e_vec = VW'(k); e_bp = m_prio[k];
         end
      e_rv = |m_act;
      e_rp = '0;
      for (int l = 7; l >= 0; l--) if (m_act[l]) e_rp = PW'(l);
      e_req = f && (!e_rv || (!m_nop && e_bp < e_rp));
   endtask

   task automatic cmp(input string tag);
      logic ok;
      meval();
      ok = (irq_req === e_req) && (run_valid === e_rv) &&
           (!e_rv || run_prio === e_rp) &&
           (!e_req || (vector_num === e_vec && req_prio === e_bp));
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got req=%0b vec=%0d prio=%0d run=%0b/%0d, expected req=%0b vec=%0d prio=%0d run=%0b/%0d",
                  tag, irq_req, vector_num, req_prio, run_valid, run_prio,
                  e_req, e_vec, e_bp, e_rv, e_rp);
      end
   endtask

   // advance one clock, updating the reference from the driven inputs
   task automatic step();
      logic [N-1:0] rise;
      logic [7:0]   low;
      meval();
      rise = irq_in & ~m_prev;
      m_prev = irq_in;
      low = m_act & (~m_act + 8'd1);
      if (irq_done) m_act = m_act & ~low;
      if (irq_ack && e_req) begin
         m_pend[e_vec] = 1'b0;
         m_act[e_bp] = 1'b1;
      end
      m_pend = m_pend | rise;
      if (wr_en) begin
         if (wr_addr == 4'd0) m_nop = wr_data[0];
         else if (wr_addr == 4'd1) m_en = wr_data;
         else if (wr_addr >= 4'd2 && wr_addr <= 4'd5)
            for (int i = 0; i < 8; i++) m_prio[(int'(wr_addr) - 2) * 8 + i] = wr_data[4*i +: 3];
      end
      @(posedge clk); #1;
      irq_ack = 1'b0; irq_done = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; step();
   endtask

   task automatic set_prio(input int src, input logic [2:0] p);
      logic [31:0] w;
      int g;
      g = src / 8;
      w = '0;
      for (int i = 0; i < 8; i++)
         w[4*i +: 3] = (g*8 + i == src) ? p : m_prio[g*8 + i];
      wr(4'(2 + g), w);
   endtask

   // serve or finish until idle
   task automatic drain(input string tag);
      for (int n = 0; n < 8; n++) begin
         meval();
         if (e_req) irq_ack = 1'b1;
         else if (e_rv) irq_done = 1'b1;
         else break;
         step();
         cmp(tag);
      end
   endtask

   initial begin
      for (int k = 0; k < N; k++) m_prio[k] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp("R1");

      // R2: latch while disabled, present on enable
      irq_in[5] = 1'b1; step(); cmp("R2");
      wr(4'd1, 32'hFFFF_FFFF); cmp("R2");
      irq_ack = 1'b1; step(); cmp("R5");
      irq_done = 1'b1; step(); cmp("R8");
      irq_in[5] = 1'b0; step();

      // R10: distinct priorities in one word, serve in order
      wr(4'd3, 32'h0123_4567);
      irq_in[15:8] = 8'hFF; step(); cmp("R10");
      for (int n = 0; n < 8; n++) begin
         irq_ack = 1'b1; step(); cmp("R10");
         irq_done = 1'b1; step(); cmp("R10");
      end
      irq_in[15:8] = '0; step();

      // sweep both modes over every priority pair
      for (int m = 0; m < 2; m++) begin
         wr(4'd0, 32'(m));
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
               set_prio(2, 3'(a));
               set_prio(17, 3'(b));
               irq_in[2] = 1'b1; step(); cmp("R3");
               irq_ack = 1'b1; step(); cmp("R5");
               irq_in[17] = 1'b1; step();
               cmp(m == 1 ? "R9" : (b < a ? "R6" : "R7"));
               drain("R8");
               cmp("R11");
               irq_in[2] = 1'b0; irq_in[17] = 1'b0; step();
               // simultaneous arrival: tie goes to the lower index
               irq_in[2] = 1'b1; irq_in[17] = 1'b1; step();
               cmp(a == b ? "R4" : "R3");
               drain("R8");
               irq_in[2] = 1'b0; irq_in[17] = 1'b0; step();
            end
      end

      // pseudo-random mix
      wr(4'd0, 32'd0);
      begin
         logic [15:0] lf;
         lf = 16'hACE1;
         for (int t = 0; t < 1500; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[5]) irq_in[lf[4:0]] = ~irq_in[lf[4:0]];
            irq_ack  = lf[6];
            irq_done = lf[7] & lf[8];
            if (lf[11:9] == 3'd0) begin
               wr_en = 1'b1;
               wr_addr = 4'(2 + lf[13:12]);
               wr_data = {lf, lf ^ 16'h5A5A};
            end else if (lf[11:8] == 4'd1) begin
               wr_en = 1'b1; wr_addr = 4'd0; wr_data = {31'd0, lf[14]};
            end
            step();
            cmp("R3");
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule